// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Control

This block holds the receive-side control state of a serial port. A separate bit-level receiver reports each completed frame as a single-cycle strobe with its data word and received parity bit. It also sends a strobe for an idle line (one full frame time of logic 1) and a strobe for an overrun. The block uses these to decide whether the receiver is muted or active, checks parity with the selected sense, and keeps the receive status flags. It merges those flags and two transmit-side status levels into one level interrupt.

Software can mute or unmute the receiver at any time with a register-style write. While muted, the receiver wakes in one of two ways, chosen by a select input. In idle wakeup, the receiver wakes on an idle line. In address wakeup, the receiver wakes on an address frame that carries this node's address. In address wakeup, an address frame for another node mutes the receiver again, even if it was active. The block is meant for multi-drop links, where a node ignores traffic meant for other nodes.

Top module: `uart_rx_wake_ctrl`

## Requirements
- R1: After reset, `mute`, `rbne`, `idle_flag`, `perr`, `ovr` and `irq` are all 0.
- R2: A cycle with `mute_wr`=1 loads `mute_wdata` into the mute state, and the new state shows on `mute` after that clock edge. A `mute` value of 0 means the receiver is active.
- R3: With `wake_sel`=0, an `idle_stb` clears the mute state. The idle flag is set only when the receiver was active before that strobe.
- R4: With `wake_sel`=1, a frame whose data bit DATA_W-1 is 1 is an address frame. If its low ADDR_W bits equal `node_addr`, it clears the mute state, and the frame is accepted.
- R5: With `wake_sel`=1, an address frame whose low ADDR_W bits differ from `node_addr` sets the mute state, even from active. That frame is not accepted.
- R6: A frame is accepted only when the mute state that results from the same cycle is 0. An accepted frame sets `rbne`. A frame or overrun strobe that arrives while that resulting state is 1 sets none of `rbne`, `perr` or `ovr`.
- R7: When `par_en`=1, an accepted frame sets `perr` if `frame_par` differs from the expected bit. The expected bit is the XOR of the data word when `par_odd`=0 (even), and its inverse when `par_odd`=1 (odd). When `par_en`=0, `perr` is never set.
- R8: `irq` is the OR of five terms: (`rbne` OR `ovr`) AND `ie_rx`, `idle_flag` AND `ie_idle`, `perr` AND `ie_perr`, `tbe_lvl` AND `ie_tbe`, and `tc_lvl` AND `ie_tc`. It stays high as long as any term holds.
- R9: Each receive flag stays set until its one-cycle clear pulse arrives. If a set and a clear happen in the same cycle, the flag ends up set.
- R10: If a hardware wake or re-mute event and a software mute write happen in the same cycle, the hardware event decides the mute state.
- R11: An `idle_stb` with `wake_sel`=1 leaves the mute state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mute_wr | input | 1 | Software write strobe for the mute state |
| mute_wdata | input | 1 | Value written to the mute state |
| wake_sel | input | 1 | Wake method: 0 idle line, 1 address match |
| node_addr | input | ADDR_W | Address of this node |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| idle_stb | input | 1 | Idle line seen (one-cycle strobe) |
| frame_stb | input | 1 | Frame received (one-cycle strobe) |
| frame_data | input | DATA_W | Data word of the received frame |
| frame_par | input | 1 | Received parity bit |
| ovr_stb | input | 1 | Overrun seen (one-cycle strobe) |
| tbe_lvl | input | 1 | Transmit buffer empty status level |
| tc_lvl | input | 1 | Transmission complete status level |
| ie_rx | input | 1 | Enable for receive-not-empty and overrun |
| ie_idle | input | 1 | Enable for idle flag |
| ie_perr | input | 1 | Enable for parity error flag |
| ie_tbe | input | 1 | Enable for transmit buffer empty |
| ie_tc | input | 1 | Enable for transmission complete |
| clr_rbne | input | 1 | Clear pulse for receive-not-empty |
| clr_idle | input | 1 | Clear pulse for idle flag |
| clr_perr | input | 1 | Clear pulse for parity error |
| clr_ovr | input | 1 | Clear pulse for overrun |
| mute | output | 1 | Mute state (1 muted) |
| rbne | output | 1 | Receive-not-empty flag |
| idle_flag | output | 1 | Idle line flag |
| perr | output | 1 | Parity error flag |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Combined interrupt level |

## Verification
The bench targets frames and strobes that land in the same cycle as a software mute write or a flag clear. A design that let software win would leave a node muted after its own address arrived. A design that let the clear win would lose a received frame. It sends a mismatched address frame while the receiver is active, which a design that only handles wakeups would accept. It also sends idle strobes in address mode, which a careless design would treat as a wakeup. Frames with both parity senses and either parity bit show any inverted parity rule, and clearing flags with their enables toggled shows any interrupt that is gated wrongly or latched.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
   typedef enum int unsigned {
      FL_RBNE = 0,
      FL_IDLE = 1,
      FL_PERR = 2,
      FL_OVR  = 3
   } rx_flag_e;

   localparam int unsigned NUM_RX_FLAGS = 4;
   localparam int unsigned NUM_IRQ_SRC  = 6;

   typedef struct packed {
      logic is_addr;
      logic addr_hit;
      logic par_bad;
   } frame_info_t;
endpackage

// File: rtl/uart_wake_frame_chk.sv
module uart_wake_frame_chk
   import uart_wake_pkg::*;
#(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [DATA_W-1:0] data,
   input  logic              par_bit,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [ADDR_W-1:0] node_addr,
   output frame_info_t       info
);
   localparam int unsigned FLAG_BIT = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W >= DATA_W) begin : g_bad_addr
         $error("ADDR_W must be between 1 and DATA_W-1");
      end
   endgenerate

   logic expect_bit;

   always_comb begin
      expect_bit    = (^data) ^ par_odd;
      info.is_addr  = data[FLAG_BIT];
      info.addr_hit = (data[ADDR_W-1:0] == node_addr);
      info.par_bad  = par_en && (par_bit != expect_bit);
   end
endmodule

// File: rtl/uart_wake_mute_ctl.sv
module uart_wake_mute_ctl
   import uart_wake_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sw_wr,
   input  logic        sw_val,
   input  logic        wake_sel,
   input  logic        idle_stb,
   input  logic        frame_stb,
   input  frame_info_t info,
   output logic        mute_q,
   output logic        mute_nxt
);
   always_comb begin
      mute_nxt = mute_q;
      if (sw_wr) mute_nxt = sw_val;
      if (!wake_sel && idle_stb) mute_nxt = 1'b0;
      if (wake_sel && frame_stb && info.is_addr) mute_nxt = !info.addr_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mute_q <= 1'b0;
      else        mute_q <= mute_nxt;
   end

   a_r3_idle_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_sel && idle_stb) |=> !mute_q);
   a_r4_match_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sel && frame_stb && info.is_addr && info.addr_hit) |=> !mute_q);
   a_r5_miss_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sel && frame_stb && info.is_addr && !info.addr_hit) |=> mute_q);
   a_r11_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_sel && idle_stb && !sw_wr && !(frame_stb && info.is_addr))
      |=> $stable(mute_q));
endmodule

// File: rtl/uart_wake_flag_bank.sv
module uart_wake_flag_bank #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("flag bank needs at least one flag");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
         end

         a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
         a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !q[i]);
      end
   endgenerate
endmodule

// File: rtl/uart_wake_irq_merge.sv
module uart_wake_irq_merge #(
   parameter int unsigned N_SRC = 6
) (
   input  logic [N_SRC-1:0] src,
   input  logic [N_SRC-1:0] en,
   output logic             irq
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("irq merge needs at least one source");
      end
   endgenerate

   always_comb irq = |(src & en);
endmodule

// File: rtl/uart_rx_wake_ctrl.sv
module uart_rx_wake_ctrl
   import uart_wake_pkg::*;
#(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mute_wr,
   input  logic              mute_wdata,
   input  logic              wake_sel,
   input  logic [ADDR_W-1:0] node_addr,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              idle_stb,
   input  logic              frame_stb,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              frame_par,
   input  logic              ovr_stb,
   input  logic              tbe_lvl,
   input  logic              tc_lvl,
   input  logic              ie_rx,
   input  logic              ie_idle,
   input  logic              ie_perr,
   input  logic              ie_tbe,
   input  logic              ie_tc,
   input  logic              clr_rbne,
   input  logic              clr_idle,
   input  logic              clr_perr,
   input  logic              clr_ovr,
   output logic              mute,
   output logic              rbne,
   output logic              idle_flag,
   output logic              perr,
   output logic              ovr,
   output logic              irq
);
   frame_info_t                 info;
   logic                        mute_q;
   logic                        mute_nxt;
   logic                        accept;
   logic [NUM_RX_FLAGS-1:0]     fl_set;
   logic [NUM_RX_FLAGS-1:0]     fl_clr;
   logic [NUM_RX_FLAGS-1:0]     fl_q;
   logic [NUM_IRQ_SRC-1:0]      irq_src;
   logic [NUM_IRQ_SRC-1:0]      irq_en;

   uart_wake_frame_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
      .data      (frame_data),
      .par_bit   (frame_par),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .node_addr (node_addr),
      .info      (info)
   );

   uart_wake_mute_ctl mute_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_wr     (mute_wr),
      .sw_val    (mute_wdata),
      .wake_sel  (wake_sel),
      .idle_stb  (idle_stb),
      .frame_stb (frame_stb),
      .info      (info),
      .mute_q    (mute_q),
      .mute_nxt  (mute_nxt)
   );

   always_comb begin
      accept          = frame_stb && !mute_nxt;
      fl_set          = '0;
      fl_set[FL_RBNE] = accept;
      fl_set[FL_IDLE] = idle_stb && !mute_q;
      fl_set[FL_PERR] = accept && info.par_bad;
      fl_set[FL_OVR]  = ovr_stb && !mute_nxt;
      fl_clr          = '0;
      fl_clr[FL_RBNE] = clr_rbne;
      fl_clr[FL_IDLE] = clr_idle;
      fl_clr[FL_PERR] = clr_perr;
      fl_clr[FL_OVR]  = clr_ovr;
   end

   uart_wake_flag_bank #(.N(NUM_RX_FLAGS)) flags_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (fl_set),
      .clr   (fl_clr),
      .q     (fl_q)
   );

   always_comb begin
      irq_src = {tc_lvl, tbe_lvl, fl_q[FL_PERR], fl_q[FL_IDLE],
                 fl_q[FL_OVR], fl_q[FL_RBNE]};
      irq_en  = {ie_tc, ie_tbe, ie_perr, ie_idle, ie_rx, ie_rx};
   end

   uart_wake_irq_merge #(.N_SRC(NUM_IRQ_SRC)) irq_i (
      .src (irq_src),
      .en  (irq_en),
      .irq (irq)
   );

   assign mute      = mute_q;
   assign rbne      = fl_q[FL_RBNE];
   assign idle_flag = fl_q[FL_IDLE];
   assign perr      = fl_q[FL_PERR];
   assign ovr       = fl_q[FL_OVR];

   a_r6_mute_blocks_rbne: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_nxt && !rbne) |=> !rbne);
   a_r6_mute_blocks_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_nxt && !ovr) |=> !ovr);
   a_r7_no_check_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_en && !perr) |=> !perr);
   a_r8_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !(ie_rx || ie_idle || ie_perr || ie_tbe || ie_tc) |-> !irq);
   a_r2_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_wr && !idle_stb && !frame_stb) |=> (mute == $past(mute_wdata)));
endmodule

// File: tb/uart_rx_wake_ctrl_tb_top.sv
module uart_rx_wake_ctrl_tb_top;
   localparam int DATA_W = 9;
   localparam int ADDR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mute_wr, mute_wdata, wake_sel, par_en, par_odd;
   logic [ADDR_W-1:0] node_addr;
   logic idle_stb, frame_stb, frame_par, ovr_stb, tbe_lvl, tc_lvl;
   logic [DATA_W-1:0] frame_data;
   logic ie_rx, ie_idle, ie_perr, ie_tbe, ie_tc;
   logic clr_rbne, clr_idle, clr_perr, clr_ovr;
   logic mute, rbne, idle_flag, perr, ovr, irq;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic m_mute, m_rbne, m_idle, m_perr, m_ovr;

   always #10 clk = ~clk;

   uart_rx_wake_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .mute_wr(mute_wr), .mute_wdata(mute_wdata),
      .wake_sel(wake_sel), .node_addr(node_addr), .par_en(par_en),
      .par_odd(par_odd), .idle_stb(idle_stb), .frame_stb(frame_stb),
      .frame_data(frame_data), .frame_par(frame_par), .ovr_stb(ovr_stb),
      .tbe_lvl(tbe_lvl), .tc_lvl(tc_lvl), .ie_rx(ie_rx), .ie_idle(ie_idle),
      .ie_perr(ie_perr), .ie_tbe(ie_tbe), .ie_tc(ie_tc),
      .clr_rbne(clr_rbne), .clr_idle(clr_idle), .clr_perr(clr_perr),
      .clr_ovr(clr_ovr), .mute(mute), .rbne(rbne), .idle_flag(idle_flag),
      .perr(perr), .ovr(ovr), .irq(irq)
   );

   function automatic logic parity_bad(logic [DATA_W-1:0] d, logic p,
                                       logic en, logic odd);
      return en && (p != ((^d) ^ odd));
   endfunction

   function automatic logic irq_expect(logic rb, logic ov, logic id, logic pe);
      return ((rb || ov) && ie_rx) || (id && ie_idle) || (pe && ie_perr) ||
             (tbe_lvl && ie_tbe) || (tc_lvl && ie_tc);
   endfunction

   task automatic check(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      mute_wr = 0; mute_wdata = 0; idle_stb = 0; frame_stb = 0;
      frame_data = '0; frame_par = 0; ovr_stb = 0;
      clr_rbne = 0; clr_idle = 0; clr_perr = 0; clr_ovr = 0;
   endtask

   // apply current inputs for one cycle (called at a negedge), update model, compare
   task automatic step(string tag);
      logic nm, acc;
      nm = m_mute;
      if (mute_wr) nm = mute_wdata;
      if (!wake_sel && idle_stb) nm = 1'b0;
      if (wake_sel && frame_stb && frame_data[DATA_W-1])
         nm = (frame_data[ADDR_W-1:0] != node_addr);
      acc = frame_stb && !nm;
      m_idle = (idle_stb && !m_mute) || (m_idle && !clr_idle);
      m_rbne = acc || (m_rbne && !clr_rbne);
      m_perr = (acc && parity_bad(frame_data, frame_par, par_en, par_odd))
               || (m_perr && !clr_perr);
      m_ovr  = (ovr_stb && !nm) || (m_ovr && !clr_ovr);
      m_mute = nm;
      @(negedge clk);
      check({tag, " R2 R3 R4 R5 R10 R11 mute"}, mute, m_mute);
      check({tag, " R6 R9 rbne"}, rbne, m_rbne);
      check({tag, " R3 R9 idle_flag"}, idle_flag, m_idle);
      check({tag, " R7 R9 perr"}, perr, m_perr);
      check({tag, " R6 R9 ovr"}, ovr, m_ovr);
      check({tag, " R8 irq"}, irq, irq_expect(m_rbne, m_ovr, m_idle, m_perr));
      idle_inputs();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      idle_inputs();
      wake_sel = 0; node_addr = 4'h5; par_en = 1; par_odd = 0;
      tbe_lvl = 0; tc_lvl = 0;
      ie_rx = 1; ie_idle = 1; ie_perr = 1; ie_tbe = 0; ie_tc = 0;
      m_mute = 0; m_rbne = 0; m_idle = 0; m_perr = 0; m_ovr = 0;
      repeat (3) @(negedge clk);
      check("R1 mute", mute, 1'b0);
      check("R1 rbne", rbne, 1'b0);
      check("R1 idle", idle_flag, 1'b0);
      check("R1 perr", perr, 1'b0);
      check("R1 ovr", ovr, 1'b0);
      check("R1 irq", irq, 1'b0);
      rst_n = 1;
      @(negedge clk);

      // R2: software mute, frames dropped while muted (R6)
      mute_wr = 1; mute_wdata = 1; step("R2 write");
      frame_stb = 1; frame_data = 9'h033; frame_par = 0; ovr_stb = 1;
      step("R6 muted frame");
      // R3: idle wake, idle flag not set since muted before
      idle_stb = 1; step("R3 idle wake");
      idle_stb = 1; step("R3 idle active");
      clr_idle = 1; step("R9 clear idle");
      // R7 even and odd parity
      frame_stb = 1; frame_data = 9'h007; frame_par = 1; step("R7 even ok");
      clr_rbne = 1; frame_stb = 1; frame_data = 9'h007; frame_par = 0;
      step("R7 even bad R9 set wins");
      clr_perr = 1; clr_rbne = 1; step("R9 clear");
      par_odd = 1; frame_stb = 1; frame_data = 9'h007; frame_par = 0;
      step("R7 odd ok");
      frame_stb = 1; frame_data = 9'h007; frame_par = 1; step("R7 odd bad");
      par_en = 0; clr_perr = 1; clr_rbne = 1; frame_stb = 1;
      frame_data = 9'h001; frame_par = 0; step("R7 disabled");
      clr_rbne = 1; step("R9 clear rbne");
      // address mode
      wake_sel = 1;
      frame_stb = 1; frame_data = 9'h10A; step("R5 miss from active");
      idle_stb = 1; step("R11 idle in addr mode");
      frame_stb = 1; frame_data = 9'h025; step("R6 data while muted");
      mute_wr = 1; mute_wdata = 1; frame_stb = 1; frame_data = 9'h105;
      step("R4 R10 match beats write");
      mute_wr = 1; mute_wdata = 0; frame_stb = 1; frame_data = 9'h103;
      step("R5 R10 miss beats write");
      // R8 transmit sources
      ie_rx = 0; ie_idle = 0; ie_perr = 0; tbe_lvl = 1; ie_tbe = 1;
      step("R8 tbe");
      ie_tbe = 0; tc_lvl = 1; ie_tc = 1; step("R8 tc");
      ie_tc = 0; step("R8 all off");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         wake_sel = ($urandom % 2);
         par_en = ($urandom % 4) != 0;
         par_odd = $urandom % 2;
         ie_rx = $urandom % 2; ie_idle = $urandom % 2; ie_perr = $urandom % 2;
         ie_tbe = $urandom % 2; ie_tc = $urandom % 2;
         tbe_lvl = $urandom % 2; tc_lvl = $urandom % 2;
         mute_wr = ($urandom % 10) == 0; mute_wdata = $urandom % 2;
         idle_stb = ($urandom % 6) == 0;
         frame_stb = ($urandom % 3) == 0;
         frame_data = DATA_W'($urandom);
         if ($urandom % 2) frame_data[ADDR_W-1:0] = node_addr;
         frame_par = $urandom % 2;
         ovr_stb = ($urandom % 7) == 0;
         clr_rbne = ($urandom % 5) == 0; clr_idle = ($urandom % 5) == 0;
         clr_perr = ($urandom % 5) == 0; clr_ovr = ($urandom % 5) == 0;
         step("rand");
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule